// File: doc/BRIEF.md
# Table-Accumulate Binary-to-BCD Converter

This block turns a 16-bit unsigned binary number into six packed decimal (BCD) digits. It does not use the shift-and-add-3 method. It scans the latched input one bit per clock, starting at the least significant bit. Whenever the current bit is set, it adds the BCD form of that bit's power of two into a six-digit decimal accumulator. The powers of two are computed as constants when the design is built. A ripple of decimal-adjusting digit adders performs each addition within one clock.

A request is made by raising `start` while the block is idle. The input is captured on that edge and the accumulator is cleared. After sixteen bit-steps and one finishing state, the result is copied to the output register and `ready` is high for exactly one cycle. The output keeps that value until the next conversion completes. Reset is synchronous and active low.

Top module: `bcd_accum_conv`

## Requirements
- R1: While `rst_n` is low and in the cycles after its release with no request, `ready` is 0 and `bcd_out` is all zero. A `start` given during reset begins no conversion.
- R2: A conversion of value V leaves decimal digit k of V in `bcd_out[4k+3:4k]`, for k = 0 (units) through 5. No digit-adder carry leaves the top digit during a conversion.
- R3: If the rising edge that accepts `start` is counted as edge 1, `ready` rises after edge 18 and stays high for exactly one cycle.
- R4: `start` is ignored while a conversion is in progress. Changes on `bin_in` after the accepting edge do not alter the result or its timing.
- R5: `bcd_out` changes only on the edge that raises `ready`, and it holds its value between completions.
- R6: Every 4-bit digit of `bcd_out` is in the range 0 to 9.
- R7: An input of 65535 gives digits 0,6,5,5,3,5 (`bcd_out` = 24'h065535), and an input of 0 gives 24'h000000.
- R8: While `start` is held high, a new conversion is accepted on the edge that ends the `ready` pulse. Results then arrive every 18 cycles.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| start | input | 1 | Conversion request, sampled while idle |
| bin_in | input | 16 | Unsigned binary value, captured on acceptance |
| ready | output | 1 | One-cycle completion pulse |
| bcd_out | output | 24 | Six packed BCD digits, units in bits 3:0 |

## Verification
Two events can fall on the same clock edge: the end of one completion pulse and the acceptance of the next request.

The bench provokes this by holding `start` high through a `ready` pulse. It changes `bin_in` in the cycle where `ready` is high. It then checks three things:
- the pulse lasts exactly one cycle;
- the finished result stays on `bcd_out` throughout the next conversion;
- the second value appears 18 cycles later.

Separately, a request raised in the middle of a conversion must leave both the result and the latency unchanged.

// File: rtl/bcd_conv_pkg.sv
// Package: shared types and elaboration-time helpers for the converter.
// Assumes: callers pass values small enough to fit in 64 bits.
package bcd_conv_pkg;

    // Controller states: waiting, scanning bits, publishing the result.
    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_RUN  = 2'd1,
        ST_DONE = 2'd2
    } conv_state_t;

    // Decimal digit k of v, used to build BCD constants at elaboration.
    function automatic logic [3:0] dec_digit(input longint unsigned v, input int k);
        longint unsigned t;
        t = v;
        for (int i = 0; i < k; i++) t = t / 10;
        return 4'(t % 10);
    endfunction

endpackage

// File: rtl/bcd_digit_add.sv
// Module: one decimal digit adder with carry.
// Adds two BCD digits and a carry-in. A raw sum above 9 is corrected by
// adding 6, and a carry-out is produced. Assumes both inputs are 0..9.
module bcd_digit_add (
    input  logic [3:0] a,
    input  logic [3:0] b,
    input  logic       cin,
    output logic [3:0] sum,
    output logic       cout
);
    logic [4:0] raw;
    logic [4:0] adj;

    // Binary sum, then the decimal correction when it exceeds nine.
    always_comb begin
        raw  = {1'b0, a} + {1'b0, b} + {4'd0, cin};
        adj  = raw + 5'd6;
        cout = (raw > 5'd9);
        sum  = cout ? adj[3:0] : raw[3:0];
    end
endmodule

// File: rtl/bcd_word_add.sv
// Module: multi-digit BCD adder built from a ripple of digit adders.
// The carry passes through all digits within one cycle. The top carry is
// brought out so that overflow can be observed. Assumes valid BCD inputs.
module bcd_word_add #(
    parameter int DIG = 6,
    localparam int W = DIG * 4
) (
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    output logic [W-1:0] sum,
    output logic         carry_out
);
    logic [DIG:0] c;

    assign c[0] = 1'b0;

    genvar k;
    generate
        for (k = 0; k < DIG; k++) begin : g_dig
            bcd_digit_add u_dig (
                .a    (a[4*k +: 4]),
                .b    (b[4*k +: 4]),
                .cin  (c[k]),
                .sum  (sum[4*k +: 4]),
                .cout (c[k+1])
            );
        end
    endgenerate

    assign carry_out = c[DIG];
endmodule

// File: rtl/bcd_pow2_rom.sv
// Module: constant table of 2^0 .. 2^(BIN_W-1) held in packed BCD.
// Entries are computed at elaboration, and idx selects one of them.
// Assumes DIG is wide enough for 2^(BIN_W-1).
module bcd_pow2_rom #(
    parameter int BIN_W = 16,
    parameter int DIG   = 6,
    localparam int IDX_W = $clog2(BIN_W),
    localparam int W     = DIG * 4
) (
    input  logic [IDX_W-1:0] idx,
    output logic [W-1:0]     val
);
    import bcd_conv_pkg::*;

    logic [W-1:0] tbl [BIN_W];

    genvar k, d;
    generate
        for (k = 0; k < BIN_W; k++) begin : g_ent
            for (d = 0; d < DIG; d++) begin : g_d
                assign tbl[k][4*d +: 4] = dec_digit(64'd1 << k, d);
            end
        end
    endgenerate

    // Table lookup for the bit position being scanned.
    always_comb val = tbl[idx];
endmodule

// File: rtl/bcd_accum_conv.sv
// Module: top-level table-accumulate binary-to-BCD converter.
// Scans the captured input one bit per cycle, LSB first, and adds the BCD
// power of two for each set bit. A finishing state then publishes the
// result with a one-cycle ready pulse. Assumes a synchronous, active-low reset.
module bcd_accum_conv #(
    parameter int BIN_W = 16,
    parameter int DIG   = 6,
    localparam int IDX_W = $clog2(BIN_W),
    localparam int W     = DIG * 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic [BIN_W-1:0] bin_in,
    output logic             ready,
    output logic [W-1:0]     bcd_out
);
    import bcd_conv_pkg::*;

    localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(BIN_W - 1);

    conv_state_t      state;
    logic [BIN_W-1:0] shreg;
    logic [IDX_W-1:0] bit_idx;
    logic [W-1:0]     acc;
    logic [W-1:0]     term;
    logic [W-1:0]     acc_next;
    logic             acc_ovf;

    bcd_pow2_rom #(.BIN_W(BIN_W), .DIG(DIG)) u_rom (
        .idx (bit_idx),
        .val (term)
    );

    bcd_word_add #(.DIG(DIG)) u_add (
        .a         (acc),
        .b         (term),
        .sum       (acc_next),
        .carry_out (acc_ovf)
    );

    // Controller, bit scan, accumulation and result publication.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state   <= ST_IDLE;
            shreg   <= '0;
            bit_idx <= '0;
            acc     <= '0;
            bcd_out <= '0;
            ready   <= 1'b0;
        end else begin
            ready <= 1'b0;
            unique case (state)
                ST_IDLE: if (start) begin
                    shreg   <= bin_in;
                    acc     <= '0;
                    bit_idx <= '0;
                    state   <= ST_RUN;
                end
                ST_RUN: begin
                    if (shreg[0]) acc <= acc_next;
                    shreg   <= shreg >> 1;
                    bit_idx <= bit_idx + 1'b1;
                    if (bit_idx == LAST_IDX) state <= ST_DONE;
                end
                ST_DONE: begin
                    bcd_out <= acc;
                    ready   <= 1'b1;
                    state   <= ST_IDLE;
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    // R3
    ready_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ready |=> !ready);

    // R5
    out_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !ready |-> $stable(bcd_out));

    // R2
    no_acc_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_RUN && shreg[0]) |-> !acc_ovf);

    // R4
    run_continues_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_RUN && bit_idx != LAST_IDX) |=> state == ST_RUN);

    genvar g;
    generate
        for (g = 0; g < DIG; g++) begin : g_rng
            // R6
            digit_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
                bcd_out[4*g +: 4] <= 4'd9);
        end
    endgenerate
endmodule

// File: tb/tb_bcd_accum_conv.sv
// Bench: exhaustive sweep of low values, a strided sweep of the full range,
// boundary values, requests during a conversion and back-to-back requests.
module tb_bcd_accum_conv;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [15:0] bin_in = '0;
    logic        ready;
    logic [23:0] bcd_out;

    int n_chk = 0;
    int n_err = 0;

    bcd_accum_conv dut (
        .clk(clk), .rst_n(rst_n), .start(start), .bin_in(bin_in),
        .ready(ready), .bcd_out(bcd_out)
    );

    always #5 clk = ~clk;

    function automatic logic [23:0] exp_bcd(input int v);
        logic [23:0] r;
        int t;
        t = v;
        for (int k = 0; k < 6; k++) begin
            r[4*k +: 4] = 4'(t % 10);
            t = t / 10;
        end
        return r;
    endfunction

    task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // One conversion. poke raises start mid-run with a different value.
    task automatic run_one(input int v, input bit poke, input string req);
        bit early;
        logic [23:0] e;
        e = exp_bcd(v);
        early = 1'b0;
        start = 1'b1; bin_in = 16'(v);
        for (int i = 1; i <= 18; i++) begin
            @(negedge clk);
            if (i == 1) begin start = 1'b0; bin_in = ~16'(v); end
            if (poke && i == 5) begin start = 1'b1; bin_in = 16'(v) ^ 16'h5a5a; end
            if (poke && i == 6) start = 1'b0;
            if (i < 18 && ready) early = 1'b1;
        end
        // R2 / R3 / R4: value and latency
        check(ready && !early && bcd_out == e, req, {7'd0, ready, bcd_out}, {8'h01, e});
        @(negedge clk);
        // R3 / R5: single-cycle pulse and held output
        check(!ready && bcd_out == e, "R3/R5 pulse end and hold", {7'd0, ready, bcd_out}, {8'h00, e});
    endtask

    initial begin
        repeat (195000) @(posedge clk);
        n_err++;
        $display("FAIL watchdog actual=hung expected=done");
        $display("Result: errors=%0d of %0d checks", n_err, n_chk + 1);
        $finish;
    end

    initial begin
        bit seen;
        start = 1'b1; bin_in = 16'hffff;
        repeat (3) @(negedge clk);
        // R1: reset state with start held
        check(!ready && bcd_out == '0, "R1 in reset", {7'd0, ready, bcd_out}, 32'd0);
        start = 1'b0;
        rst_n = 1'b1;
        seen = 1'b0;
        for (int i = 0; i < 25; i++) begin
            @(negedge clk);
            if (ready || bcd_out != '0) seen = 1'b1;
        end
        // R1: no conversion from the start given during reset
        check(!seen, "R1 after release", {31'd0, seen}, 32'd0);

        // R7: boundaries
        run_one(65535, 1'b0, "R7 max");
        run_one(0, 1'b0, "R7 zero");
        run_one(65535, 1'b0, "R7 max again");

        // R2: exhaustive low range
        for (int v = 0; v < 2048; v++) run_one(v, 1'b0, "R2 low sweep");
        // R2: strided sweep across the whole range
        for (int v = 2048; v < 65536; v += 37) run_one(v, 1'b0, "R2 stride sweep");

        // R4: start raised mid-conversion with another input
        run_one(12345, 1'b1, "R4 start while busy");
        run_one(59999, 1'b1, "R4 start while busy");
        run_one(40960, 1'b1, "R4 start while busy");

        // R8: start held high across completions
        begin
            int vals [3] = '{9999, 32768, 100};
            start = 1'b1; bin_in = 16'(vals[0]);
            for (int j = 0; j < 3; j++) begin
                bit early;
                early = 1'b0;
                for (int i = 1; i <= 18; i++) begin
                    @(negedge clk);
                    if (i < 18 && ready) early = 1'b1;
                    if (j > 0 && i < 18 && bcd_out != exp_bcd(vals[j-1])) early = 1'b1;
                end
                check(ready && !early && bcd_out == exp_bcd(vals[j]), "R8 back-to-back",
                      {7'd0, ready, bcd_out}, {8'h01, exp_bcd(vals[j])});
                if (j < 2) bin_in = 16'(vals[j+1]);
                else start = 1'b0;
            end
            @(negedge clk);
            check(!ready, "R8 single pulse", {31'd0, ready}, 32'd0);
        end

        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end
endmodule